// File: doc/BRIEF.md
# VME Byte-Lane Swap Controller

This block sits between the 32-bit local data path of a bus bridge and the VMEbus data lanes. It moves bytes to new lanes on the way through, in either direction. It also rebuilds the VME lane-select lines (DS1, DS0, A1, LW) so that they match the lanes that carry data after the reordering. The data and strobe path is combinational, so a transfer takes no extra cycle.

Software picks the reordering at run time. It writes 16-bit command codes to a small register set in A16 short I/O space. The set holds a command register, a status register and a read-only identification register. Two static select inputs stand in for board jumpers and place the register set at one of four base addresses. Interrupt-acknowledge cycles always pass through unchanged.

Local data is lane aligned. Byte lane 0 is bits [31:24] and lane 3 is bits [7:0]. A D8 or D16 transfer uses the low half, [15:0]. An even-addressed byte sits in [15:8] and an odd-addressed byte sits in [7:0].

Top module: `vlane_swap_ctl`

## Requirements
- R1: While reset is held and just after it is released, no swapping is enabled, the status register reads 0x0000, the command register reads 0x08FF, `loc_ack` is low and no VME strobe is driven.
- R2: The register base is 0xCF00 + 0x1000 × `base_sel`, giving 0xCF00, 0xDF00, 0xEF00 or 0xFF00. A register cycle needs all of the following: `loc_as`, `loc_short_io`, no `loc_iack`, and an address of base+0 (command), base+2 (status) or base+4 (ID). Every other cycle goes to the VME side.
- R3: `loc_ack` rises in the clock after a register cycle's strobe is first sampled and stays high for exactly one cycle. A new register access is accepted only after `loc_as` has been released. VME cycles never raise `loc_ack`.
- R4: A write to the command register with 0x01FF, 0x02FF or 0x04FF enables only byte, word or long-word swapping respectively. 0x07FF enables all three and 0x08FF disables all. Any other code changes nothing. Status bits [2:0] show the enabled modes: bit0 byte, bit1 word, bit2 long word. The command register reads back the last accepted code.
- R5: The ID register reads 0x0046. Writes to the status and ID registers have no effect.
- R6: With no swapping, data passes unchanged. D8 (`loc_size`=0) drives DS1 low for an even address and DS0 low for an odd one. D16 (`loc_size`=1) drives both DS lines low. For both sizes A1 equals address bit 1 and LW stays high. D32 (`loc_size`=2, and 3 is treated the same) drives both DS lines low, A1 low and LW low.
- R7: In byte mode, D8 data moves to the other byte lane of its 16-bit pair and DS1 and DS0 trade places. D16 and D32 pass unchanged.
- R8: In word mode, D16 and D32 exchange the two bytes in each 16-bit half, with strobes as in R6. D8 passes unchanged.
- R9: In long-word mode, D32 reverses all four lanes. D16 exchanges the bytes in each half and inverts A1. D8 exchanges the bytes in each half, trades DS1 and DS0, and inverts A1.
- R10: When several modes are enabled, long word takes precedence over word and word over byte.
- R11: During an interrupt-acknowledge cycle (`loc_iack`), data and strobes follow R6 whatever mode is enabled.
- R12: For non-register cycles, `loc_rdata` is `vme_rdata` with the same lane reordering as the write path. For register cycles, `loc_rdata` carries the register value in [15:0] with the upper bits zero.
- R13: While `loc_as` is low, or during a register cycle, DS1, DS0 and LW stay high and A1 stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_sel | input | 2 | Static register base select (jumper model) |
| loc_as | input | 1 | Local cycle strobe |
| loc_short_io | input | 1 | Cycle targets A16 short I/O space |
| loc_iack | input | 1 | Interrupt-acknowledge cycle |
| loc_write | input | 1 | 1 = write, 0 = read |
| loc_size | input | 2 | 0 = D8, 1 = D16, 2/3 = D32 |
| loc_addr | input | ADDR_W | Local address |
| loc_wdata | input | 8*LANES | Local write data, lane aligned |
| loc_rdata | output | 8*LANES | Read data back to the bridge |
| loc_ack | output | 1 | Register access acknowledge pulse |
| vme_wdata | output | 8*LANES | Reordered data toward VME |
| vme_rdata | input | 8*LANES | Data read from VME |
| vme_ds1_n | output | 1 | Upper data strobe, active low |
| vme_ds0_n | output | 1 | Lower data strobe, active low |
| vme_a1 | output | 1 | Regenerated address bit 1 |
| vme_lw_n | output | 1 | Long-word select, active low |

## Verification
The assertions check the following on every cycle:
- the acknowledge only follows a register hit and never lasts two cycles;
- register and idle cycles leave the VME strobes released;
- a D8 transfer drives exactly one data strobe;
- a D32 transfer drives LW with A1 low;
- interrupt-acknowledge data passes straight;
- the mode changes only after a register write.

The exact lane permutation and strobe inversion for each mode and size, the decode of each command code, the mode precedence, base-address selection and register read-back values can only be shown by the bench's scenarios against its reference model.

// File: rtl/vlswap_pkg.sv
`timescale 1ns/1ps
package vlswap_pkg;

    localparam int MODE_W  = 3;
    localparam int REG_W   = 16;
    localparam int MB_BYTE = 0;
    localparam int MB_WORD = 1;
    localparam int MB_LONG = 2;

    localparam logic [REG_W-1:0] CODE_BYTE = 16'h01FF;
    localparam logic [REG_W-1:0] CODE_WORD = 16'h02FF;
    localparam logic [REG_W-1:0] CODE_LONG = 16'h04FF;
    localparam logic [REG_W-1:0] CODE_ALL  = 16'h07FF;
    localparam logic [REG_W-1:0] CODE_OFF  = 16'h08FF;

    typedef enum logic [1:0] {SZ_D8 = 2'd0, SZ_D16 = 2'd1, SZ_D32 = 2'd2, SZ_WIDE = 2'd3} xfer_size_e;
    typedef enum logic [1:0] {PATH_STRAIGHT, PATH_PAIR_XCHG, PATH_REVERSE} lane_path_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ACK, ST_HOLD} reg_state_e;
    typedef enum logic [1:0] {RSEL_CMD, RSEL_STAT, RSEL_ID, RSEL_NONE} reg_sel_e;
    typedef enum logic [1:0] {EFF_NONE, EFF_BYTE, EFF_WORD, EFF_LONG} eff_mode_e;

    typedef struct packed {
        logic              ok;
        logic [MODE_W-1:0] bits;
    } cmd_dec_t;

    function automatic cmd_dec_t cmd_decode(input logic [REG_W-1:0] code);
        cmd_dec_t r;
        r.ok   = 1'b1;
        r.bits = '0;
        case (code)
            CODE_BYTE: r.bits = MODE_W'(1 << MB_BYTE);
            CODE_WORD: r.bits = MODE_W'(1 << MB_WORD);
            CODE_LONG: r.bits = MODE_W'(1 << MB_LONG);
            CODE_ALL:  r.bits = '1;
            CODE_OFF:  r.bits = '0;
            default:   r.ok   = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vlswap_lanes.sv
`timescale 1ns/1ps
module vlswap_lanes
    import vlswap_pkg::*;
#(
    parameter int LANES = 4
) (
    input  lane_path_e         path,
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    localparam int TOP = 8*LANES - 1;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int PAIR = i ^ 1;
        localparam int REV  = LANES - 1 - i;
        assign dout[TOP-8*i -: 8] =
            (path == PATH_REVERSE)   ? din[TOP-8*REV  -: 8] :
            (path == PATH_PAIR_XCHG) ? din[TOP-8*PAIR -: 8] :
                                       din[TOP-8*i    -: 8];
    end
endmodule

// File: rtl/vlswap_route.sv
`timescale 1ns/1ps
module vlswap_route
    import vlswap_pkg::*;
(
    input  logic              active,
    input  logic              iack,
    input  logic [MODE_W-1:0] mode,
    input  xfer_size_e        size,
    input  logic [1:0]        adr_lo,
    output lane_path_e        path,
    output logic              ds1_n,
    output logic              ds0_n,
    output logic              a1,
    output logic              lw_n
);
    eff_mode_e eff;
    logic      is_d8, is_d16, is_wide;
    logic      flip0, flip1, ea0, ea1;

    assign is_d8   = (size == SZ_D8);
    assign is_d16  = (size == SZ_D16);
    assign is_wide = !is_d8 && !is_d16;

    always_comb begin
        if (iack)                eff = EFF_NONE;
        else if (mode[MB_LONG])  eff = EFF_LONG;
        else if (mode[MB_WORD])  eff = EFF_WORD;
        else if (mode[MB_BYTE])  eff = EFF_BYTE;
        else                     eff = EFF_NONE;
    end

    always_comb begin
        path  = PATH_STRAIGHT;
        flip0 = 1'b0;
        flip1 = 1'b0;
        unique case (eff)
            EFF_NONE: ;
            EFF_BYTE: if (is_d8) begin
                path  = PATH_PAIR_XCHG;
                flip0 = 1'b1;
            end
            EFF_WORD: if (!is_d8) path = PATH_PAIR_XCHG;
            EFF_LONG: if (is_wide) begin
                path = PATH_REVERSE;
            end else begin
                path  = PATH_PAIR_XCHG;
                flip1 = 1'b1;
                flip0 = is_d8;
            end
        endcase
    end

    assign ea0 = adr_lo[0] ^ flip0;
    assign ea1 = adr_lo[1] ^ flip1;

    always_comb begin
        ds1_n = 1'b1;
        ds0_n = 1'b1;
        a1    = 1'b0;
        lw_n  = 1'b1;
        if (active) begin
            if (is_d8) begin
                ds1_n = ea0;
                ds0_n = !ea0;
                a1    = ea1;
            end else if (is_d16) begin
                ds1_n = 1'b0;
                ds0_n = 1'b0;
                a1    = ea1;
            end else begin
                ds1_n = 1'b0;
                ds0_n = 1'b0;
                lw_n  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/vlswap_regs.sv
`timescale 1ns/1ps
module vlswap_regs
    import vlswap_pkg::*;
#(
    parameter logic [7:0] ID_CODE = 8'h46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              hit,
    input  logic              write,
    input  reg_sel_e          sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [MODE_W-1:0] mode,
    output logic [REG_W-1:0]  rdata,
    output logic              ack
);
    reg_state_e       state_q, state_d;
    logic             take;
    cmd_dec_t         dec;
    logic [REG_W-1:0] cmd_q;

    assign take = (state_q == ST_IDLE) && hit;
    assign dec  = cmd_decode(wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hit)     state_d = ST_ACK;
            ST_ACK:  state_d = strobe ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (!strobe) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= '0;
            cmd_q <= CODE_OFF;
        end else if (take && write && sel == RSEL_CMD && dec.ok) begin
            mode  <= dec.bits;
            cmd_q <= wdata;
        end
    end

    always_comb begin
        ack = (state_q == ST_ACK);
        unique case (sel)
            RSEL_CMD:  rdata = cmd_q;
            RSEL_STAT: rdata = REG_W'(mode);
            RSEL_ID:   rdata = REG_W'(ID_CODE);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/vlane_swap_ctl.sv
`timescale 1ns/1ps
module vlane_swap_ctl
    import vlswap_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter int         LANES   = 4,
    parameter logic [7:0] ID_CODE = 8'h46
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         base_sel,
    input  logic               loc_as,
    input  logic               loc_short_io,
    input  logic               loc_iack,
    input  logic               loc_write,
    input  logic [1:0]         loc_size,
    input  logic [ADDR_W-1:0]  loc_addr,
    input  logic [8*LANES-1:0] loc_wdata,
    output logic [8*LANES-1:0] loc_rdata,
    output logic               loc_ack,
    output logic [8*LANES-1:0] vme_wdata,
    input  logic [8*LANES-1:0] vme_rdata,
    output logic               vme_ds1_n,
    output logic               vme_ds0_n,
    output logic               vme_a1,
    output logic               vme_lw_n
);
    localparam int DW = 8*LANES;

    logic [ADDR_W-1:0] base_addr;
    logic              block_match;
    reg_sel_e          sel;
    logic              reg_hit;
    logic [MODE_W-1:0] mode_q;
    logic [REG_W-1:0]  reg_rdata;
    lane_path_e        path;
    logic [DW-1:0]     rd_swapped;

    assign base_addr   = ADDR_W'({2'b11, base_sel, 12'hF00});
    assign block_match = ({loc_addr[ADDR_W-1:3], 3'b000} == base_addr);

    always_comb begin
        case (loc_addr[2:0])
            3'd0:    sel = RSEL_CMD;
            3'd2:    sel = RSEL_STAT;
            3'd4:    sel = RSEL_ID;
            default: sel = RSEL_NONE;
        endcase
    end

    assign reg_hit = loc_as && loc_short_io && !loc_iack && block_match && (sel != RSEL_NONE);

    vlswap_regs #(.ID_CODE(ID_CODE)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (loc_as),
        .hit    (reg_hit),
        .write  (loc_write),
        .sel    (sel),
        .wdata  (loc_wdata[REG_W-1:0]),
        .mode   (mode_q),
        .rdata  (reg_rdata),
        .ack    (loc_ack)
    );

    vlswap_route u_route (
        .active (loc_as && !reg_hit),
        .iack   (loc_iack),
        .mode   (mode_q),
        .size   (xfer_size_e'(loc_size)),
        .adr_lo (loc_addr[1:0]),
        .path   (path),
        .ds1_n  (vme_ds1_n),
        .ds0_n  (vme_ds0_n),
        .a1     (vme_a1),
        .lw_n   (vme_lw_n)
    );

    vlswap_lanes #(.LANES(LANES)) u_wr_lanes (
        .path (path),
        .din  (loc_wdata),
        .dout (vme_wdata)
    );

    vlswap_lanes #(.LANES(LANES)) u_rd_lanes (
        .path (path),
        .din  (vme_rdata),
        .dout (rd_swapped)
    );

    assign loc_rdata = reg_hit ? DW'(reg_rdata) : rd_swapped;
endmodule

// File: rtl/vlswap_chk.sv
`timescale 1ns/1ps
module vlswap_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          loc_as,
    input logic          loc_iack,
    input logic          loc_write,
    input logic [1:0]    loc_size,
    input logic [DW-1:0] loc_wdata,
    input logic [DW-1:0] vme_wdata,
    input logic          loc_ack,
    input logic          vme_ds1_n,
    input logic          vme_ds0_n,
    input logic          vme_a1,
    input logic          vme_lw_n,
    input logic          reg_hit,
    input logic [2:0]    mode_q
);
    AST_ACK_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |-> $past(reg_hit)); // R3
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ack |=> !loc_ack); // R3
    AST_REG_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_hit |-> (vme_ds1_n && vme_ds0_n && vme_lw_n && !vme_a1)); // R13
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_as |-> (vme_ds1_n && vme_ds0_n && vme_lw_n && !vme_a1)); // R13
    AST_IACK_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_as && loc_iack) |-> (vme_wdata == loc_wdata)); // R11
    AST_D8_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_as && !reg_hit && loc_size == 2'd0) |-> ($countones({vme_ds1_n, vme_ds0_n}) == 1)); // R6
    AST_WIDE_LONGWORD: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_as && !reg_hit && loc_size[1]) |-> (!vme_lw_n && !vme_a1 && !vme_ds1_n && !vme_ds0_n)); // R6
    AST_MODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(reg_hit && loc_write)); // R4
endmodule

bind vlane_swap_ctl vlswap_chk #(.DW(8*LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_as    (loc_as),
    .loc_iack  (loc_iack),
    .loc_write (loc_write),
    .loc_size  (loc_size),
    .loc_wdata (loc_wdata),
    .vme_wdata (vme_wdata),
    .loc_ack   (loc_ack),
    .vme_ds1_n (vme_ds1_n),
    .vme_ds0_n (vme_ds0_n),
    .vme_a1    (vme_a1),
    .vme_lw_n  (vme_lw_n),
    .reg_hit   (reg_hit),
    .mode_q    (mode_q)
);

// File: tb/vlane_swap_ctl_test.sv
`timescale 1ns/1ps
module vlane_swap_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  base_sel = 2'd2;
    logic        loc_as = 1'b0, loc_short_io = 1'b0, loc_iack = 1'b0, loc_write = 1'b0;
    logic [1:0]  loc_size = 2'd0;
    logic [15:0] loc_addr = 16'h0;
    logic [31:0] loc_wdata = 32'h0, vme_rdata = 32'h0;
    logic [31:0] loc_rdata, vme_wdata;
    logic        loc_ack, vme_ds1_n, vme_ds0_n, vme_a1, vme_lw_n;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    bit [2:0]  m_mode = 3'b000;
    bit [15:0] m_cmd = 16'h08FF;
    int        m_phase = 0;

    always #2 clk = ~clk;

    vlane_swap_ctl uut (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .loc_as(loc_as),
        .loc_short_io(loc_short_io), .loc_iack(loc_iack), .loc_write(loc_write),
        .loc_size(loc_size), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_ack(loc_ack), .vme_wdata(vme_wdata),
        .vme_rdata(vme_rdata), .vme_ds1_n(vme_ds1_n), .vme_ds0_n(vme_ds0_n),
        .vme_a1(vme_a1), .vme_lw_n(vme_lw_n)
    );

    function automatic bit [15:0] base_of(bit [1:0] s);
        return 16'hCF00 + 16'(s) * 16'h1000;
    endfunction

    function automatic bit [31:0] mv(bit [31:0] d, int perm);
        bit [31:0] r;
        for (int k = 0; k < 4; k++) begin
            int s = (perm == 2) ? 3 - k : (perm == 1) ? (k ^ 1) : k;
            r[31-8*k -: 8] = d[31-8*s -: 8];
        end
        return r;
    endfunction

    function automatic bit model_hit();
        bit [15:0] b = base_of(base_sel);
        return loc_as && loc_short_io && !loc_iack &&
               (loc_addr == b || loc_addr == b + 16'd2 || loc_addr == b + 16'd4);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int eff, perm;
        bit d8, d16, f0, f1, hit, e0, e1;
        bit [15:0] b, regv;
        bit [31:0] e_rd;
        bit e_ds1, e_ds0, e_a1, e_lw;
        hit = model_hit();
        b = base_of(base_sel);
        d8 = (loc_size == 2'd0);
        d16 = (loc_size == 2'd1);
        if (loc_iack) eff = 0;
        else if (m_mode[2]) eff = 3;
        else if (m_mode[1]) eff = 2;
        else if (m_mode[0]) eff = 1;
        else eff = 0;
        perm = 0;
        if (eff == 1) perm = d8 ? 1 : 0;
        if (eff == 2) perm = d8 ? 0 : 1;
        if (eff == 3) perm = (d8 || d16) ? 1 : 2;
        f0 = d8 && (eff == 1 || eff == 3);
        f1 = (eff == 3) && (d8 || d16);
        e0 = loc_addr[0] ^ f0;
        e1 = loc_addr[1] ^ f1;
        e_ds1 = 1; e_ds0 = 1; e_a1 = 0; e_lw = 1;
        if (loc_as && !hit) begin
            if (d8) begin e_ds1 = e0; e_ds0 = !e0; e_a1 = e1; end
            else if (d16) begin e_ds1 = 0; e_ds0 = 0; e_a1 = e1; end
            else begin e_ds1 = 0; e_ds0 = 0; e_lw = 0; end
        end
        if (hit) begin
            if (loc_addr == b) regv = m_cmd;
            else if (loc_addr == b + 16'd2) regv = {13'd0, m_mode};
            else regv = 16'h0046;
            e_rd = {16'h0, regv};
        end else begin
            e_rd = mv(vme_rdata, perm);
        end
        chk(tag, "vme_wdata", vme_wdata, mv(loc_wdata, perm));
        chk(tag, "loc_rdata", loc_rdata, e_rd);
        chk(tag, "loc_ack", 32'(loc_ack), 32'(m_phase == 1));
        chk(tag, "strobes{ds1,ds0,a1,lw}", {28'd0, vme_ds1_n, vme_ds0_n, vme_a1, vme_lw_n},
            {28'd0, e_ds1, e_ds0, e_a1, e_lw});
    endtask

    task automatic model_step();
        bit hit = model_hit();
        if (!rst_n) begin
            m_mode = 0; m_cmd = 16'h08FF; m_phase = 0;
        end else begin
            case (m_phase)
                0: if (hit) begin
                    m_phase = 1;
                    if (loc_write && loc_addr == base_of(base_sel)) begin
                        case (loc_wdata[15:0])
                            16'h01FF: begin m_mode = 3'b001; m_cmd = loc_wdata[15:0]; end
                            16'h02FF: begin m_mode = 3'b010; m_cmd = loc_wdata[15:0]; end
                            16'h04FF: begin m_mode = 3'b100; m_cmd = loc_wdata[15:0]; end
                            16'h07FF: begin m_mode = 3'b111; m_cmd = loc_wdata[15:0]; end
                            16'h08FF: begin m_mode = 3'b000; m_cmd = loc_wdata[15:0]; end
                            default: ;
                        endcase
                    end
                end
                1: m_phase = loc_as ? 2 : 0;
                default: if (!loc_as) m_phase = 0;
            endcase
        end
    endtask

    task automatic cyc(string tag);
        #1;
        compare(tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic reg_acc(bit wr, bit [15:0] a, bit [15:0] d, string tag);
        loc_as = 1; loc_short_io = 1; loc_iack = 0; loc_write = wr;
        loc_addr = a; loc_wdata = {16'h0, d}; loc_size = 2'd1;
        cyc(tag); cyc("R3"); cyc("R3");
        loc_as = 0; loc_short_io = 0;
        cyc("R13");
    endtask

    task automatic vme_acc(bit wr, bit [15:0] a, bit [1:0] sz, bit [31:0] wd,
                           bit [31:0] rd, bit ia, string tag);
        loc_as = 1; loc_short_io = 0; loc_iack = ia; loc_write = wr;
        loc_addr = a; loc_size = sz; loc_wdata = wd; vme_rdata = rd;
        cyc(tag);
        loc_as = 0; loc_iack = 0;
        cyc("R13");
    endtask

    task automatic sweep(string tag);
        for (int a = 0; a < 4; a++)
            vme_acc(1, 16'(a), 2'd0, 32'h0000_5AC3, 32'h0000_9A7E, 0, tag);
        vme_acc(1, 16'h0010, 2'd1, 32'h0000_1234, 32'h0000_ABCD, 0, tag);
        vme_acc(1, 16'h0012, 2'd1, 32'h0000_1234, 32'h0000_ABCD, 0, tag);
        vme_acc(1, 16'h0020, 2'd2, 32'h1122_3344, 32'hA1B2_C3D4, 0, tag);
        vme_acc(0, 16'h0024, 2'd3, 32'h5566_7788, 32'hDEAD_BEEF, 0, tag);
    endtask

    initial begin : main
        bit [15:0] b;
        @(negedge clk);
        cyc("R1"); cyc("R1");
        rst_n = 1;
        cyc("R1");
        b = base_of(2'd2);
        reg_acc(0, b + 16'd2, 0, "R1");
        reg_acc(0, b, 0, "R1");
        reg_acc(0, b + 16'd4, 0, "R5");
        reg_acc(1, b + 16'd4, 16'h07FF, "R5");
        reg_acc(1, b + 16'd2, 16'h04FF, "R5");
        reg_acc(0, b + 16'd2, 0, "R5");
        vme_acc(1, 16'h0000, 2'd2, 32'h0102_0304, 0, 0, "R5");
        base_sel = 2'd0; reg_acc(0, 16'hCF04, 0, "R2");
        base_sel = 2'd1; reg_acc(0, 16'hDF04, 0, "R2");
        base_sel = 2'd3; reg_acc(0, 16'hFF04, 0, "R2");
        base_sel = 2'd2;
        loc_as = 1; loc_short_io = 1; loc_write = 1; loc_size = 2'd1;
        loc_addr = 16'hDF00; loc_wdata = 32'h0000_01FF;
        cyc("R2");
        loc_addr = 16'hEF06; cyc("R2");
        loc_as = 0; cyc("R13");
        loc_as = 1; loc_addr = 16'hEF01; cyc("R2");
        loc_as = 0; loc_short_io = 0; cyc("R13");
        reg_acc(0, b + 16'd2, 0, "R2");
        vme_acc(1, 16'hEF00, 2'd1, 32'h0000_01FF, 32'h0000_4321, 0, "R2");
        reg_acc(0, b + 16'd2, 0, "R2");
        vme_acc(1, 16'h0000, 2'd0, 32'h0000_1200, 0, 0, "R6");
        vme_acc(1, 16'h0001, 2'd0, 32'h0000_0034, 0, 0, "R6");
        sweep("R6");
        reg_acc(1, b, 16'h01FF, "R4");
        reg_acc(0, b + 16'd2, 0, "R4");
        sweep("R7");
        reg_acc(1, b, 16'h02FF, "R4");
        reg_acc(0, b, 0, "R4");
        sweep("R8");
        reg_acc(1, b, 16'h03FF, "R4");
        reg_acc(1, b, 16'h02FE, "R4");
        reg_acc(0, b + 16'd2, 0, "R4");
        reg_acc(0, b, 0, "R4");
        reg_acc(1, b, 16'h04FF, "R4");
        sweep("R9");
        vme_acc(0, 16'h0001, 2'd0, 32'h0000_00C7, 32'h0000_3300, 1, "R11");
        vme_acc(0, 16'h0000, 2'd1, 32'h0000_A5B6, 32'h0000_7788, 1, "R11");
        vme_acc(0, 16'h0000, 2'd2, 32'h0102_0304, 32'hCAFE_F00D, 1, "R11");
        vme_acc(0, 16'h0040, 2'd2, 32'h0, 32'h8899_AABB, 0, "R12");
        vme_acc(0, 16'h0043, 2'd0, 32'h0, 32'h0000_EE11, 0, "R12");
        reg_acc(0, b + 16'd2, 0, "R12");
        reg_acc(1, b, 16'h07FF, "R4");
        reg_acc(0, b + 16'd2, 0, "R10");
        sweep("R10");
        reg_acc(1, b, 16'h08FF, "R4");
        reg_acc(0, b, 0, "R4");
        vme_acc(1, 16'h0002, 2'd0, 32'h0000_6600, 0, 0, "R6");
        loc_as = 1; loc_short_io = 1; loc_write = 0; loc_addr = b + 16'd4;
        cyc("R3");
        loc_as = 0; loc_short_io = 0;
        cyc("R3"); cyc("R13");
        loc_as = 1; loc_short_io = 1; loc_write = 1; loc_addr = b; loc_wdata = 32'h0000_04FF;
        cyc("R3"); cyc("R3"); cyc("R3");
        loc_wdata = 32'h0000_02FF; cyc("R3"); cyc("R3");
        loc_as = 0; loc_short_io = 0; cyc("R13");
        reg_acc(0, b + 16'd2, 0, "R3");
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule